// File: doc/BRIEF.md
# FIFO-Level Interrupt Bid Generator

This block sits beside each serial channel and turns the state of its two character FIFOs into interrupt bids for a central priority arbiter. The receiver bid grows with the number of characters waiting in the receive FIFO. The transmitter bid grows with the number of free slots in the transmit FIFO. In both bids the count is the most significant field, so the more urgent a FIFO becomes, the more likely it is to win arbitration.

Each direction has its own 2-bit trigger-level select, which sets the fill or free-space level at which bidding begins. Each direction also has a mask bit, which suppresses bidding completely. The bid also carries a source-type code and the fixed channel number of the instance. Both outputs are registered.

Top module: `fbid_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both valid flags are 0 and both bids are all zeros.
- R2: A valid receiver bid carries the receive FIFO occupancy (0 to 8) in bits 9:6.
- R3: A valid transmitter bid carries the transmit FIFO free space in bits 9:6. Free space is 8 minus the transmit fill count.
- R4: The receiver bids when the occupancy is at least the selected threshold. Level select 0 means occupancy ≥ 1, 1 means ≥ 4, 2 means ≥ 6 and 3 means ≥ 8.
- R5: The transmitter bids when the free space is at least the selected threshold. Level select 0 means free space ≥ 1, 1 means ≥ 4, 2 means ≥ 6 and 3 means ≥ 8.
- R6: When a direction's enable (mask) bit is 0, that direction's valid flag stays 0 for every count and level.
- R7: A valid bid has the type code in bits 5:3: 3'b110 for the receiver and 3'b101 for the transmitter. Bit 2 is 0, and bits 1:0 hold the channel number.
- R8: When a valid flag is 0, the matching bid is all zeros.
- R9: Outputs change one clock edge after the inputs change, and not before.
- R10: A count input above 8 is treated as 8. A receive count above 8 gives occupancy 8. A transmit fill count above 8 gives free space 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_id | input | 2 | Fixed channel number of this instance |
| rx_count | input | 4 | Receive FIFO occupancy |
| rx_level | input | 2 | Receiver trigger-level select |
| rx_enable | input | 1 | Receiver bid mask bit (1 = may bid) |
| tx_fill | input | 4 | Transmit FIFO occupancy |
| tx_level | input | 2 | Transmitter trigger-level select |
| tx_enable | input | 1 | Transmitter bid mask bit (1 = may bid) |
| rx_bid_valid | output | 1 | Receiver bid present |
| rx_bid | output | 10 | Receiver bid value |
| tx_bid_valid | output | 1 | Transmitter bid present |
| tx_bid | output | 10 | Transmitter bid value |

## Verification
The assertions check, on every cycle, the following properties:
- an idle bid reads as zero;
- each valid bid has the correct type code, the zero bit and the channel number of the previous cycle;
- a masked or empty-of-reason source stays silent;
- a full receive FIFO or an empty transmit FIFO always bids when enabled.

Only the bench scenarios can show the following:
- the exact threshold for each level select;
- the arithmetic of the free-space count;
- the clamping of out-of-range counts;
- the one-cycle latency.

The bench shows these by sweeping every count value, including out-of-range ones, against every level, with the mask set and cleared.

// File: rtl/fbid_pkg.sv
package fbid_pkg;
   localparam int SRC_W = 3;
   localparam logic [SRC_W-1:0] SRC_RX = 3'b110;
   localparam logic [SRC_W-1:0] SRC_TX = 3'b101;
endpackage

// File: rtl/fbid_level_cmp.sv
module fbid_level_cmp #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic [CNT_W-1:0] metric,
   input  logic [1:0]       level,
   output logic             hit
);
   localparam logic [CNT_W-1:0] TH_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] TH_HALF = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] TH_3Q   = CNT_W'((3 * DEPTH) / 4);
   localparam logic [CNT_W-1:0] TH_ALL  = CNT_W'(DEPTH);

   logic [CNT_W-1:0] thresh;

   always_comb begin
      unique case (level)
         2'd0:    thresh = TH_ONE;
         2'd1:    thresh = TH_HALF;
         2'd2:    thresh = TH_3Q;
         default: thresh = TH_ALL;
      endcase
      hit = (metric >= thresh);
   end
endmodule

// File: rtl/fbid_source.sv
module fbid_source
   import fbid_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CHAN_W = 2,
   parameter bit IS_TX = 1'b0,
   parameter int CNT_W = 4,
   parameter int BID_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [1:0]        level,
   input  logic              enable,
   input  logic [CHAN_W-1:0] chan,
   output logic              bid_vld,
   output logic [BID_W-1:0]  bid
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] occ;
   logic [CNT_W-1:0] metric;
   logic [SRC_W-1:0] src_code;
   logic             hit;
   logic             next_vld;

   always_comb occ = (cnt_in > DEPTH_C) ? DEPTH_C : cnt_in;

   generate
      if (IS_TX) begin : g_tx
         always_comb metric   = DEPTH_C - occ;
         always_comb src_code = SRC_TX;
      end else begin : g_rx
         always_comb metric   = occ;
         always_comb src_code = SRC_RX;
      end
   endgenerate

   fbid_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_cmp (
      .metric(metric),
      .level (level),
      .hit   (hit)
   );

   always_comb next_vld = enable & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bid_vld <= 1'b0;
         bid     <= '0;
      end else begin
         bid_vld <= next_vld;
         bid     <= next_vld ? {metric, src_code, 1'b0, chan} : '0;
      end
   end
endmodule

// File: rtl/fbid_gen.sv
module fbid_gen
   import fbid_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int CHAN_W = 2,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
   localparam int BID_W = CNT_W + SRC_W + 1 + CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAN_W-1:0] chan_id,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [1:0]        rx_level,
   input  logic              rx_enable,
   input  logic [CNT_W-1:0]  tx_fill,
   input  logic [1:0]        tx_level,
   input  logic              tx_enable,
   output logic              rx_bid_valid,
   output logic [BID_W-1:0]  rx_bid,
   output logic              tx_bid_valid,
   output logic [BID_W-1:0]  tx_bid
);
   initial begin
      assert (FIFO_DEPTH >= 4 && FIFO_DEPTH % 4 == 0)
         else $error("fbid_gen: FIFO_DEPTH must be a multiple of 4");
      assert (CHAN_W >= 1)
         else $error("fbid_gen: CHAN_W must be at least 1");
   end

   fbid_source #(.DEPTH(FIFO_DEPTH), .CHAN_W(CHAN_W), .IS_TX(1'b0),
                 .CNT_W(CNT_W), .BID_W(BID_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .cnt_in(rx_count), .level(rx_level),
      .enable(rx_enable), .chan(chan_id), .bid_vld(rx_bid_valid), .bid(rx_bid)
   );

   fbid_source #(.DEPTH(FIFO_DEPTH), .CHAN_W(CHAN_W), .IS_TX(1'b1),
                 .CNT_W(CNT_W), .BID_W(BID_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .cnt_in(tx_fill), .level(tx_level),
      .enable(tx_enable), .chan(chan_id), .bid_vld(tx_bid_valid), .bid(tx_bid)
   );
endmodule

// File: rtl/fbid_gen_chk.sv
module fbid_gen_chk
   import fbid_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int CHAN_W = 2,
   parameter int CNT_W = 4,
   parameter int BID_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CHAN_W-1:0] chan_id,
   input logic [CNT_W-1:0]  rx_count,
   input logic              rx_enable,
   input logic [CNT_W-1:0]  tx_fill,
   input logic              tx_enable,
   input logic              rx_bid_valid,
   input logic [BID_W-1:0]  rx_bid,
   input logic              tx_bid_valid,
   input logic [BID_W-1:0]  tx_bid
);
   localparam int TOP = CHAN_W + 1;

   // R6
   rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !rx_bid_valid);
   // R6
   tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> !tx_bid_valid);
   // R8
   rx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_bid_valid |-> rx_bid == '0);
   // R8
   tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_bid_valid |-> tx_bid == '0);
   // R7
   rx_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable |=> !rx_bid_valid ||
         (rx_bid[TOP+SRC_W-1:TOP] == SRC_RX && !rx_bid[CHAN_W] &&
          rx_bid[CHAN_W-1:0] == $past(chan_id)));
   // R7
   tx_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enable |=> !tx_bid_valid ||
         (tx_bid[TOP+SRC_W-1:TOP] == SRC_TX && !tx_bid[CHAN_W] &&
          tx_bid[CHAN_W-1:0] == $past(chan_id)));
   // R4
   rx_empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count == '0 |=> !rx_bid_valid);
   // R5
   tx_full_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fill >= CNT_W'(FIFO_DEPTH) |=> !tx_bid_valid);
   // R4
   rx_full_bids_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && rx_count >= CNT_W'(FIFO_DEPTH)) |=> rx_bid_valid);
   // R5
   tx_empty_bids_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_enable && tx_fill == '0) |=> tx_bid_valid);
endmodule

bind fbid_gen fbid_gen_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CHAN_W(CHAN_W),
                             .CNT_W(CNT_W), .BID_W(BID_W)) i_fbid_gen_chk (
   .clk(clk), .rst_n(rst_n), .chan_id(chan_id), .rx_count(rx_count),
   .rx_enable(rx_enable), .tx_fill(tx_fill), .tx_enable(tx_enable),
   .rx_bid_valid(rx_bid_valid), .rx_bid(rx_bid),
   .tx_bid_valid(tx_bid_valid), .tx_bid(tx_bid)
);

// File: tb/test_fbid_gen.sv
module test_fbid_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] chan_id = '0;
   logic [3:0] rx_count = '0;
   logic [1:0] rx_level = '0;
   logic       rx_enable = 1'b0;
   logic [3:0] tx_fill = '0;
   logic [1:0] tx_level = '0;
   logic       tx_enable = 1'b0;
   logic       rx_bid_valid, tx_bid_valid;
   logic [9:0] rx_bid, tx_bid;

   int total = 0;
   int failed = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fbid_gen i_fbid_gen (
      .clk(clk), .rst_n(rst_n), .chan_id(chan_id),
      .rx_count(rx_count), .rx_level(rx_level), .rx_enable(rx_enable),
      .tx_fill(tx_fill), .tx_level(tx_level), .tx_enable(tx_enable),
      .rx_bid_valid(rx_bid_valid), .rx_bid(rx_bid),
      .tx_bid_valid(tx_bid_valid), .tx_bid(tx_bid)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int thr(input int lvl);
      case (lvl)
         0: return 1;
         1: return 4;
         2: return 6;
         default: return 8;
      endcase
   endfunction

   initial begin
      #1600000;
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      rx_count = 4'd8; tx_fill = 4'd0; rx_enable = 1'b1; tx_enable = 1'b1;
      @(negedge clk);
      check("R1 rx_valid in reset", rx_bid_valid, 0);
      check("R1 rx_bid in reset", rx_bid, 0);
      check("R1 tx_valid in reset", tx_bid_valid, 0);
      check("R1 tx_bid in reset", tx_bid, 0);
      rx_count = 4'd0; tx_fill = 4'd8;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rx_valid after reset", rx_bid_valid, 0);
      check("R1 tx_valid after reset", tx_bid_valid, 0);

      // sweeps: every enable, level and count
      for (int en = 0; en < 2; en++) begin
         for (int lvl = 0; lvl < 4; lvl++) begin
            for (int c = 0; c < 16; c++) begin
               int occ, fr, evr, evt, ebr, ebt;
               @(negedge clk);
               rx_enable = en[0]; tx_enable = en[0];
               rx_level = lvl[1:0]; tx_level = 2'(3 - lvl);
               rx_count = c[3:0]; tx_fill = c[3:0];
               chan_id = 2'(c + lvl);
               occ = (c > 8) ? 8 : c;
               fr = 8 - occ;
               evr = (en == 1 && occ >= thr(lvl)) ? 1 : 0;
               evt = (en == 1 && fr >= thr(3 - lvl)) ? 1 : 0;
               ebr = evr ? ((occ << 6) | (6 << 3) | ((c + lvl) % 4)) : 0;
               ebt = evt ? ((fr << 6) | (5 << 3) | ((c + lvl) % 4)) : 0;
               @(negedge clk);
               if (en == 0) begin
                  check("R6 rx masked", rx_bid_valid, 0);
                  check("R6 tx masked", tx_bid_valid, 0);
                  check("R8 rx masked bid zero", rx_bid, 0);
                  check("R8 tx masked bid zero", tx_bid, 0);
               end else if (c > 8) begin
                  check("R10 rx clamp valid", rx_bid_valid, evr);
                  check("R10 rx clamp bid", rx_bid, ebr);
                  check("R10 tx clamp valid", tx_bid_valid, evt);
                  check("R10 tx clamp bid", tx_bid, ebt);
               end else begin
                  check("R4 rx level valid", rx_bid_valid, evr);
                  check("R5 tx level valid", tx_bid_valid, evt);
                  if (evr) begin
                     check("R2 rx count field", rx_bid[9:6], occ);
                     check("R7 rx fields", rx_bid[5:0], ebr & 63);
                  end else check("R8 rx idle zero", rx_bid, 0);
                  if (evt) begin
                     check("R3 tx space field", tx_bid[9:6], fr);
                     check("R7 tx fields", tx_bid[5:0], ebt & 63);
                  end else check("R8 tx idle zero", tx_bid, 0);
               end
            end
         end
      end

      // R9 latency: no change before the edge, change after it
      @(negedge clk);
      rx_enable = 1'b1; tx_enable = 1'b1; rx_level = 2'd0; tx_level = 2'd0;
      rx_count = 4'd0; tx_fill = 4'd8; chan_id = 2'd2;
      @(negedge clk);
      rx_count = 4'd5; tx_fill = 4'd3;
      #2;
      check("R9 rx unchanged before edge", rx_bid_valid, 0);
      check("R9 tx unchanged before edge", tx_bid_valid, 0);
      @(negedge clk);
      check("R9 rx after one edge", rx_bid, (5 << 6) | (6 << 3) | 2);
      check("R9 tx after one edge", tx_bid, (5 << 6) | (5 << 3) | 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule